// File: doc/BRIEF.md
# Confidence-Gated Fetch Throttle

This block sits beside the branch predictor in a processor front end. Every predicted conditional branch gets a confidence rating. The block then holds instruction fetch back while too many unresolved branches carry a low rating. Fetch effort on paths that are likely to be wrong is the cost this saves. The rating needs two things. The first is a run of correct outcomes in a 64-entry table of 4-bit counters. The table is indexed by PC word bits XORed with a short history of predicted directions. The second is that the branch must fall outside a short window that opens after every detected misprediction.

Each predicted branch carries a tag into a 16-entry tracking buffer. The buffer holds the branch's rating and its table index until it resolves. A resolved misprediction flushes every tracked branch. A count of unresolved low-rated branches is compared with a programmable threshold to form the fetch gate. Three event counters let software compute how well low ratings cover mispredictions and how accurate they are.

Top module: `fetch_throttle`

## Requirements
- R1: The table index of a predict is `pred_pcw_i XOR history`. The 4-bit history shifts left and takes in `pred_taken_i` as its new bit 0 on every accepted predict. It resets to 0.
- R2: `pred_conf_o` is combinational in the predict cycle. It is 1 only when the indexed counter is at least 15 and no post-mispredict window is open. A value of 1 means high confidence and 0 means low confidence.
- R3: A resolve of a tracked tag updates the counter at the index stored for that branch. A mispredict sets it to 0. A correct outcome adds 1, and the counter holds at 15. The update takes effect from the next cycle.
- R4: After a tracked mispredict resolves, the next 4 accepted predicts are rated low, whatever their counters hold.
- R5: `fetch_gate_o` is 1 while the unresolved low count is at or above `gate_thr_i`. A threshold of 0 disables gating. The gate drops in the cycle after the resolve that takes the count below the threshold.
- R6: The low count rises by 1 for each accepted low-rated predict. It falls by 1 for each correct resolve of a tracked low-rated branch. When both happen in the same cycle, the count is unchanged.
- R7: A mispredict resolve of a tracked tag untracks every branch and sets the low count to 0 on the next cycle. A predict in that same cycle is discarded: it is not tracked, does not shift history, does not use up a window slot and is not counted.
- R8: A resolve whose tag is not tracked has no effect. This holds even when it is flagged as a mispredict.
- R9: `perf_gated_o` counts cycles with both `fetch_req_i` and `fetch_gate_o` high. `perf_low_o` counts accepted low-rated predicts. `perf_low_mp_o` counts mispredict resolves of tracked low-rated branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Branch predict event |
| pred_pcw_i | input | 6 | PC word-address bits of the branch |
| pred_taken_i | input | 1 | Predicted direction |
| pred_tag_i | input | 4 | Tag of the new branch; must not be tracked already |
| pred_conf_o | output | 1 | Confidence of the current predict, 1 = high |
| res_valid_i | input | 1 | Branch resolve event |
| res_tag_i | input | 4 | Tag of the resolving branch; differs from a same-cycle predict tag |
| res_mispred_i | input | 1 | Resolving branch was mispredicted |
| gate_thr_i | input | 5 | Low-count threshold for gating, 0 disables |
| fetch_req_i | input | 1 | Fetch request, used for gated-cycle counting |
| fetch_gate_o | output | 1 | Fetch must stall |
| perf_gated_o | output | 32 | Gated fetch-request cycles |
| perf_low_o | output | 32 | Low-rated branches |
| perf_low_mp_o | output | 32 | Low-rated branches that mispredicted |

## Verification
The hardest situation to reach is a branch that reaches high confidence while the history and the distance window interfere. The counter needs 15 correct outcomes at one index, but the index moves whenever the history moves. The directed phase therefore drives a single always-taken PC until the history saturates and the entry is trained. It then mispredicts a different PC, so the window can be seen forcing 4 low ratings on a trained entry, after which the fifth predict comes out high. A random phase follows with a small set of PCs, taken-biased directions, overlapping predict and resolve, stray tags and changing thresholds. It is compared cycle by cycle against a behavioural model.

// File: rtl/fetch_throttle_pkg.sv
package fetch_throttle_pkg;
  localparam int CONF_N_DEF  = 15;
  localparam int WIN_LEN_DEF = 4;

  typedef struct packed {
    logic hit;
    logic low;
  } res_info_t;
endpackage

// File: rtl/ft_conf_table.sv
module ft_conf_table #(
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 4,
  parameter int HIST_W = 4,
  parameter int CONF_N = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pred_acc_i,
  input  logic [IDX_W-1:0] pred_pcw_i,
  input  logic             pred_taken_i,
  output logic [IDX_W-1:0] pred_idx_o,
  output logic             cnt_ok_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_mispred_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CONF_THR = CNT_W'(CONF_N);

  logic [HIST_W-1:0] hist_q;
  logic [CNT_W-1:0]  ctr_q [ENTRIES];

  assign pred_idx_o = pred_pcw_i ^ IDX_W'(hist_q);
  assign cnt_ok_o   = ctr_q[pred_idx_o] >= CONF_THR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (pred_acc_i) hist_q <= {hist_q[HIST_W-2:0], pred_taken_i};
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctr_q[g] <= '0;
      else if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        if (upd_mispred_i)          ctr_q[g] <= '0;
        else if (ctr_q[g] != CNT_MAX) ctr_q[g] <= ctr_q[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ft_track_buf.sv
module ft_track_buf
  import fetch_throttle_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ins_en_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  input  logic             ins_low_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic             res_valid_i,
  input  logic [TAG_W-1:0] res_tag_i,
  output res_info_t        res_o,
  output logic [IDX_W-1:0] res_idx_o
);
  localparam int SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0] valid_q;
  logic [SLOTS-1:0] low_q;
  logic [IDX_W-1:0] idx_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        low_q[g]   <= 1'b0;
        idx_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (ins_en_i && ins_tag_i == TAG_W'(g)) begin
        valid_q[g] <= 1'b1;
        low_q[g]   <= ins_low_i;
        idx_q[g]   <= ins_idx_i;
      end else if (res_valid_i && res_tag_i == TAG_W'(g)) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  assign res_o.hit = res_valid_i & valid_q[res_tag_i];
  assign res_o.low = low_q[res_tag_i];
  assign res_idx_o = idx_q[res_tag_i];
endmodule

// File: rtl/ft_gate_ctrl.sv
module ft_gate_ctrl #(
  parameter int TAG_W   = 4,
  parameter int WIN_LEN = 4,
  parameter int PERF_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_acc_i,
  input  logic              pred_low_i,
  input  logic              res_hit_i,
  input  logic              res_low_i,
  input  logic              flush_i,
  input  logic [TAG_W:0]    thr_i,
  input  logic              fetch_req_i,
  output logic              win_act_o,
  output logic [TAG_W:0]    low_cnt_o,
  output logic              gate_o,
  output logic [PERF_W-1:0] perf_gated_o,
  output logic [PERF_W-1:0] perf_low_o,
  output logic [PERF_W-1:0] perf_low_mp_o
);
  localparam int LC_W  = TAG_W + 1;
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  logic [LC_W-1:0]   low_cnt_q;
  logic [WIN_W-1:0]  win_q;
  logic [PERF_W-1:0] gated_q, low_q, low_mp_q;
  logic              add_low, sub_low;

  assign add_low   = pred_acc_i & pred_low_i;
  assign sub_low   = res_hit_i & res_low_i;
  assign win_act_o = win_q != '0;
  assign low_cnt_o = low_cnt_q;
  assign gate_o    = (thr_i != '0) && (low_cnt_q >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      win_q     <= '0;
    end else if (flush_i) begin
      low_cnt_q <= '0;
      win_q     <= WIN_W'(WIN_LEN);
    end else begin
      low_cnt_q <= low_cnt_q + LC_W'(add_low) - LC_W'(sub_low);
      if (pred_acc_i && win_act_o) win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gated_q  <= '0;
      low_q    <= '0;
      low_mp_q <= '0;
    end else begin
      gated_q  <= gated_q + PERF_W'(fetch_req_i & gate_o);
      low_q    <= low_q + PERF_W'(add_low);
      low_mp_q <= low_mp_q + PERF_W'(flush_i & res_low_i);
    end
  end

  assign perf_gated_o  = gated_q;
  assign perf_low_o    = low_q;
  assign perf_low_mp_o = low_mp_q;
endmodule

// File: rtl/fetch_throttle.sv
module fetch_throttle
  import fetch_throttle_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 4,
  parameter int HIST_W  = 4,
  parameter int TAG_W   = 4,
  parameter int CONF_N  = CONF_N_DEF,
  parameter int WIN_LEN = WIN_LEN_DEF,
  parameter int PERF_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_valid_i,
  input  logic [IDX_W-1:0]  pred_pcw_i,
  input  logic              pred_taken_i,
  input  logic [TAG_W-1:0]  pred_tag_i,
  output logic              pred_conf_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic              res_mispred_i,
  input  logic [TAG_W:0]    gate_thr_i,
  input  logic              fetch_req_i,
  output logic              fetch_gate_o,
  output logic [PERF_W-1:0] perf_gated_o,
  output logic [PERF_W-1:0] perf_low_o,
  output logic [PERF_W-1:0] perf_low_mp_o
);
  logic [IDX_W-1:0] pred_idx, res_idx;
  logic             cnt_ok, win_act, flush, pred_acc, pred_low;
  logic [TAG_W:0]   low_cnt;
  res_info_t        res;

  // a tracked mispredict discards everything in flight, including this cycle's predict
  assign flush       = res.hit & res_mispred_i;
  assign pred_acc    = pred_valid_i & ~flush;
  assign pred_conf_o = cnt_ok & ~win_act;
  assign pred_low    = ~pred_conf_o;

  ft_conf_table #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .HIST_W(HIST_W), .CONF_N(CONF_N)
  ) i_table (
    .clk_i, .rst_ni,
    .pred_acc_i   (pred_acc),
    .pred_pcw_i   (pred_pcw_i),
    .pred_taken_i (pred_taken_i),
    .pred_idx_o   (pred_idx),
    .cnt_ok_o     (cnt_ok),
    .upd_en_i     (res.hit),
    .upd_idx_i    (res_idx),
    .upd_mispred_i(res_mispred_i)
  );

  ft_track_buf #(.TAG_W(TAG_W), .IDX_W(IDX_W)) i_track (
    .clk_i, .rst_ni,
    .flush_i    (flush),
    .ins_en_i   (pred_acc),
    .ins_tag_i  (pred_tag_i),
    .ins_low_i  (pred_low),
    .ins_idx_i  (pred_idx),
    .res_valid_i(res_valid_i),
    .res_tag_i  (res_tag_i),
    .res_o      (res),
    .res_idx_o  (res_idx)
  );

  ft_gate_ctrl #(.TAG_W(TAG_W), .WIN_LEN(WIN_LEN), .PERF_W(PERF_W)) i_gate (
    .clk_i, .rst_ni,
    .pred_acc_i   (pred_acc),
    .pred_low_i   (pred_low),
    .res_hit_i    (res.hit),
    .res_low_i    (res.low),
    .flush_i      (flush),
    .thr_i        (gate_thr_i),
    .fetch_req_i  (fetch_req_i),
    .win_act_o    (win_act),
    .low_cnt_o    (low_cnt),
    .gate_o       (fetch_gate_o),
    .perf_gated_o (perf_gated_o),
    .perf_low_o   (perf_low_o),
    .perf_low_mp_o(perf_low_mp_o)
  );
endmodule

// File: rtl/fetch_throttle_chk.sv
module fetch_throttle_chk #(
  parameter int TAG_W  = 4,
  parameter int PERF_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pred_valid_i,
  input logic              pred_conf_o,
  input logic              res_valid_i,
  input logic              res_hit,
  input logic              flush,
  input logic              win_act,
  input logic [TAG_W:0]    low_cnt,
  input logic [TAG_W:0]    gate_thr_i,
  input logic              fetch_req_i,
  input logic              fetch_gate_o,
  input logic [PERF_W-1:0] perf_gated_o
);
  a_r4_window_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i && win_act |-> !pred_conf_o);

  a_r5_thr_zero_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_thr_i == '0 |-> !fetch_gate_o);

  a_r6_low_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush |=> ({1'b0, low_cnt} <= {1'b0, $past(low_cnt)} + 1'b1));

  a_r7_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> low_cnt == '0);

  a_r8_stray_resolve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_hit && !pred_valid_i |=> $stable(low_cnt));

  a_r9_gated_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_req_i && fetch_gate_o) |=> $stable(perf_gated_o));
endmodule

bind fetch_throttle fetch_throttle_chk #(.TAG_W(TAG_W), .PERF_W(PERF_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pred_valid_i(pred_valid_i),
  .pred_conf_o (pred_conf_o),
  .res_valid_i (res_valid_i),
  .res_hit     (res.hit),
  .flush       (flush),
  .win_act     (win_act),
  .low_cnt     (low_cnt),
  .gate_thr_i  (gate_thr_i),
  .fetch_req_i (fetch_req_i),
  .fetch_gate_o(fetch_gate_o),
  .perf_gated_o(perf_gated_o)
);

// File: tb/test_fetch_throttle.sv
module test_fetch_throttle;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pv = 0, tk = 0, rv = 0, rm = 0, freq = 0;
  logic [5:0]  pcw = '0;
  logic [3:0]  ptag = '0, rtag = '0;
  logic [4:0]  thr = '0;
  logic        conf, gate;
  logic [31:0] p_gated, p_low, p_lowmp;

  fetch_throttle i_fetch_throttle (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pv), .pred_pcw_i(pcw), .pred_taken_i(tk), .pred_tag_i(ptag),
    .pred_conf_o(conf),
    .res_valid_i(rv), .res_tag_i(rtag), .res_mispred_i(rm),
    .gate_thr_i(thr), .fetch_req_i(freq), .fetch_gate_o(gate),
    .perf_gated_o(p_gated), .perf_low_o(p_low), .perf_low_mp_o(p_lowmp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int tbl[64];
  int hist = 0, win = 0, lowcnt = 0;
  bit vld[16], lw[16];
  int ix[16];
  int m_gated = 0, m_low = 0, m_lowmp = 0;
  int last_conf = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // sample at negedge+1, compare, advance model, move to next negedge
  task automatic tick();
    int midx, mconf, mgate;
    bit hit, fl, acc;
    #1;
    midx  = int'(pcw) ^ hist;
    mconf = (tbl[midx] >= 15 && win == 0) ? 1 : 0;
    mgate = (thr != 0 && lowcnt >= int'(thr)) ? 1 : 0;
    hit   = rv && vld[rtag];
    fl    = hit && rm;
    acc   = pv && !fl;
    if (pv) begin
      check("R1,R2,R3,R4", "pred_conf_o", int'(conf), mconf);
      last_conf = int'(conf);
    end
    check("R5,R6,R7", "fetch_gate_o", int'(gate), mgate);
    check("R9", "perf_gated_o", int'(p_gated), m_gated);
    check("R9", "perf_low_o", int'(p_low), m_low);
    check("R9", "perf_low_mp_o", int'(p_lowmp), m_lowmp);
    if (freq && mgate == 1) m_gated++;
    if (acc && mconf == 0) m_low++;
    if (fl && lw[rtag]) m_lowmp++;
    if (hit) begin
      if (rm) tbl[ix[rtag]] = 0;
      else if (tbl[ix[rtag]] < 15) tbl[ix[rtag]]++;
    end
    if (fl) begin
      foreach (vld[i]) vld[i] = 0;
      lowcnt = 0;
      win = 4;
    end else begin
      if (hit) begin
        vld[rtag] = 0;
        if (lw[rtag]) lowcnt--;
      end
      if (acc) begin
        vld[ptag] = 1;
        lw[ptag] = (mconf == 0);
        ix[ptag] = midx;
        if (mconf == 0) lowcnt++;
        if (win > 0) win--;
      end
    end
    if (acc) hist = ((hist << 1) | int'(tk)) & 15;
    @(negedge clk);
    pv = 0; rv = 0; rm = 0;
  endtask

  function automatic int free_tag();
    int s = $urandom % 16;
    for (int k = 0; k < 16; k++) if (!vld[(s + k) % 16]) return (s + k) % 16;
    return -1;
  endfunction

  function automatic int busy_tag();
    int s = $urandom % 16;
    for (int k = 0; k < 16; k++) if (vld[(s + k) % 16]) return (s + k) % 16;
    return -1;
  endfunction

  task automatic predict(int pc, bit taken, output int tag);
    tag = free_tag();
    pv = 1; pcw = 6'(pc); tk = taken; ptag = 4'(tag);
    tick();
  endtask

  task automatic resolve(int tag, bit mis);
    rv = 1; rtag = 4'(tag); rm = mis;
    tick();
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, tags[5];
    foreach (tbl[i]) tbl[i] = 0;
    foreach (vld[i]) begin vld[i] = 0; lw[i] = 0; ix[i] = 0; end
    @(negedge clk); @(negedge clk);
    check("R5", "reset gate", int'(gate), 0);
    check("R9", "reset perf_low", int'(p_low), 0);
    rst_n = 1;
    @(negedge clk);

    // train one always-taken branch to saturation
    thr = 5'd0;
    for (int n = 0; n < 24; n++) begin
      predict(16, 1, t);
      resolve(t, 0);
    end
    predict(16, 1, t);
    check("R2", "trained branch high", last_conf, 1);
    resolve(t, 0);

    // mispredict another PC: window forces 4 lows on the trained entry
    thr = 5'd2;
    predict(32, 1, t);
    resolve(t, 1);
    for (int n = 0; n < 5; n++) begin
      predict(16, 1, tags[n]);
      check("R4", "window rating", last_conf, (n < 4) ? 0 : 1);
    end
    check("R5", "gate with 4 low outstanding", int'(gate), 1);
    resolve(tags[0], 0);
    resolve(tags[1], 0);
    check("R5", "gate at count 2", int'(gate), 1);
    resolve(tags[2], 0);
    check("R5", "gate released at count 1", int'(gate), 0);
    thr = 5'd1;
    #1 check("R5", "gate at thr 1", int'(gate), 1);
    @(negedge clk);
    thr = 5'd0;
    #1 check("R5", "thr 0 disables", int'(gate), 0);
    @(negedge clk);

    // stray mispredict resolve: no window, no flush
    thr = 5'd1;
    resolve((tags[3] + 8) % 16, 1);
    check("R8", "stray resolve keeps gate", int'(gate), 1);
    predict(16, 1, t);
    check("R8", "no window after stray", last_conf, 1);
    resolve(t, 0);

    // same-cycle low predict and low resolve (open a window first)
    predict(40, 1, t);
    resolve(t, 1);
    predict(16, 1, tags[0]);
    predict(16, 1, tags[1]);
    pv = 1; pcw = 6'd16; tk = 1; ptag = 4'(free_tag()); t = int'(ptag);
    rv = 1; rtag = 4'(tags[0]); rm = 0;
    tick();
    check("R6", "net-zero count keeps gate", int'(gate), 1);

    // flush with a discarded same-cycle predict
    pv = 1; pcw = 6'd16; tk = 0; ptag = 4'(free_tag());
    rv = 1; rtag = 4'(tags[1]); rm = 1;
    tick();
    check("R7", "gate cleared by flush", int'(gate), 0);
    resolve(t, 1);
    check("R7", "flushed tag untracked", int'(gate), 0);
    predict(16, 1, t);
    check("R7", "window restarted", last_conf, 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int f, b;
      if ($urandom % 64 == 0) thr = 5'($urandom % 4);
      freq = 1'($urandom % 2);
      f = free_tag();
      b = busy_tag();
      if (f >= 0 && $urandom % 2 == 1) begin
        pv = 1; pcw = 6'(16 + $urandom % 4); tk = ($urandom % 8) != 0; ptag = 4'(f);
      end
      if (b >= 0 && $urandom % 2 == 1) begin
        rv = 1; rtag = 4'(b); rm = ($urandom % 12) == 0;
      end else if ($urandom % 20 == 0 && f >= 0 && !(pv && int'(ptag) == f)) begin
        rv = 1; rtag = 4'(f); rm = 1;
      end
      tick();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule